// File: doc/BRIEF.md
# Comparator-Driven Set/Reset Latch Controller

This block holds a single set/reset latch whose set input comes from a comparator 1 level and whose reset input comes from a comparator 2 level. Each input is gated by its own enable bit. Software can also set or reset the latch at any time through two pulse bits that clear themselves. An 8-bit control register is written over a simple write-strobe interface and read back combinationally. The comparator levels enter through a two-flop synchronizer. The synchronized levels are reported unchanged as status outputs, whatever the latch configuration.

Each of the two output pins has its own selector. One setting drives the pin with its own synchronized comparator level. The other drives it with the latch output. A pin can therefore act as a plain comparator output, or as a latched and pulse-stretched version of the comparator activity.

Top module: `cmp_srlatch_ctrl`

## Requirements
- R1: Control bit 7 selects the source of `pin2_out`: 1 gives the latch output, 0 gives the synchronized comparator 2 level.
- R2: Control bit 6 selects the source of `pin1_out`: 1 gives the latch output, 0 gives the synchronized comparator 1 level.
- R3: When control bit 5 is 1, a high synchronized comparator 1 level sets the latch on the next clock edge. When bit 5 is 0, comparator 1 leaves the latch unchanged.
- R4: When control bit 4 is 1, a high synchronized comparator 2 level clears the latch on the next clock edge. When bit 4 is 0, comparator 2 leaves the latch unchanged.
- R5: Writing 1 to control bit 3 sets the latch one edge after the write edge. Bit 3 always reads 0.
- R6: Writing 1 to control bit 2 clears the latch one edge after the write edge. Bit 2 always reads 0.
- R7: Control bits 1 and 0 ignore writes and always read 0. A write of 1s to them leaves the latch unchanged.
- R8: After reset, every control bit reads 0, the latch output is 0, and both pins carry the raw comparator levels.
- R9: `cmp1_stat` and `cmp2_stat` always equal the synchronized comparator levels, for every control setting.
- R10: When a set source and a reset source are active in the same cycle, the latch is cleared.
- R11: A comparator input change reaches its status and raw pin output after two clock edges. It reaches the latch on the third edge.
- R12: A write stores control bits 7 to 4 at the write edge, and they read back on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read data |
| cmp1_in | input | 1 | Comparator 1 level (asynchronous) |
| cmp2_in | input | 1 | Comparator 2 level (asynchronous) |
| cmp1_stat | output | 1 | Synchronized comparator 1 level |
| cmp2_stat | output | 1 | Synchronized comparator 2 level |
| pin1_out | output | 1 | Output pin 1 (comparator 1 or latch) |
| pin2_out | output | 1 | Output pin 2 (comparator 2 or latch) |

## Verification
The assertions check on every cycle that each pin matches the source its select bit names, and that the unimplemented and pulse bits read 0. They also check that the latch obeys reset-wins priority, holds when no source is active, follows a gated comparator, and that stored bits match the last write. Only the bench's scenarios show the full sweep of all sixteen enable/select combinations against both comparator levels and both prior latch states, the exact synchronizer latency, and the simultaneous pulse requests. The bench observes the latch state through the pins after switching them to latch mode.

// File: rtl/srl_pkg.sv
// Package: shared field positions and the configuration type for the
// comparator set/reset latch controller. Assumes an 8-bit control register.
package srl_pkg;
    localparam int REG_W     = 8;
    localparam int N_CMP     = 2;
    localparam int SEL2_BIT  = 7;
    localparam int SEL1_BIT  = 6;
    localparam int SETEN_BIT = 5;
    localparam int RSTEN_BIT = 4;
    localparam int PSET_BIT  = 3;
    localparam int PRST_BIT  = 2;

    typedef struct packed {
        logic sel2;
        logic sel1;
        logic set_en;
        logic rst_en;
    } srl_cfg_t;
endpackage

// File: rtl/srl_sync.sv
// Module: multi-stage flop synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent level; no bus coherence is implied.
module srl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the asynchronous inputs in the first stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Shift the value one stage further
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/srl_ctrl_reg.sv
// Module: control register. It stores the pin selects and source enables,
// and turns writes of the two pulse bits into one-cycle requests. Pulse and
// unimplemented bits always read 0.
module srl_ctrl_reg
    import srl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output srl_cfg_t         cfg,
    output logic             pls_set,
    output logic             pls_rst,
    output logic [REG_W-1:0] rd_data
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[PRST_BIT-1:0];

    // Hold the writable configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.sel2   <= wr_data[SEL2_BIT];
            cfg.sel1   <= wr_data[SEL1_BIT];
            cfg.set_en <= wr_data[SETEN_BIT];
            cfg.rst_en <= wr_data[RSTEN_BIT];
        end
    end

    // Produce one-cycle pulse requests that clear themselves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pls_set <= 1'b0;
            pls_rst <= 1'b0;
        end else begin
            pls_set <= wr_en & wr_data[PSET_BIT];
            pls_rst <= wr_en & wr_data[PRST_BIT];
        end
    end

    // Assemble the read view; pulse and unused bits read 0
    always_comb begin
        rd_data            = '0;
        rd_data[SEL2_BIT]  = cfg.sel2;
        rd_data[SEL1_BIT]  = cfg.sel1;
        rd_data[SETEN_BIT] = cfg.set_en;
        rd_data[RSTEN_BIT] = cfg.rst_en;
    end
endmodule

// File: rtl/srl_latch_core.sv
// Module: set/reset latch state with gated comparator sources and pulse
// requests. Reset has priority over set. Assumes synchronized inputs.
module srl_latch_core (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_set,
    input  logic cmp_rst,
    input  logic set_en,
    input  logic rst_en,
    input  logic pls_set,
    input  logic pls_rst,
    output logic set_eff,
    output logic rst_eff,
    output logic q
);
    // Combine the gated comparator sources with the pulse requests
    always_comb begin
        set_eff = (cmp_set & set_en) | pls_set;
        rst_eff = (cmp_rst & rst_en) | pls_rst;
    end

    // Update the latch state with reset taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (rst_eff) q <= 1'b0;
        else if (set_eff) q <= 1'b1;
    end
endmodule

// File: rtl/srl_pin_mux.sv
// Module: per-pin selector between the raw synchronized comparator level and
// the latch output. Purely combinational.
module srl_pin_mux #(
    parameter int N_PINS = 2
) (
    input  logic [N_PINS-1:0] sel,
    input  logic [N_PINS-1:0] raw,
    input  logic              q,
    output logic [N_PINS-1:0] pin
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        // Drive each pin from the latch or its own comparator
        assign pin[p] = sel[p] ? q : raw[p];
    end
endmodule

// File: rtl/cmp_srlatch_ctrl.sv
// Module: top of the comparator-driven set/reset latch controller. It
// synchronizes the two comparator levels, holds the control register, runs
// the latch and drives the two output pins. Assumes comparator inputs are
// asynchronous levels and reset is synchronous, active low.
module cmp_srlatch_ctrl
    import srl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             cmp1_in,
    input  logic             cmp2_in,
    output logic             cmp1_stat,
    output logic             cmp2_stat,
    output logic             pin1_out,
    output logic             pin2_out
);
    logic [N_CMP-1:0] cmp_sync;
    logic [N_CMP-1:0] pins;
    srl_cfg_t         cfg;
    logic             pls_set;
    logic             pls_rst;
    logic             set_eff;
    logic             rst_eff;
    logic             latch_q;

    srl_sync #(.W(N_CMP), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmp2_in, cmp1_in}),
        .q     (cmp_sync)
    );

    srl_ctrl_reg ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .pls_set (pls_set),
        .pls_rst (pls_rst),
        .rd_data (rd_data)
    );

    srl_latch_core core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_set (cmp_sync[0]),
        .cmp_rst (cmp_sync[1]),
        .set_en  (cfg.set_en),
        .rst_en  (cfg.rst_en),
        .pls_set (pls_set),
        .pls_rst (pls_rst),
        .set_eff (set_eff),
        .rst_eff (rst_eff),
        .q       (latch_q)
    );

    srl_pin_mux #(.N_PINS(N_CMP)) mux_i (
        .sel (/* pin index 1 = pin2 */ {cfg.sel2, cfg.sel1}),
        .raw (cmp_sync),
        .q   (latch_q),
        .pin (pins)
    );

    assign cmp1_stat = cmp_sync[0];
    assign cmp2_stat = cmp_sync[1];
    assign pin1_out  = pins[0];
    assign pin2_out  = pins[1];
endmodule

// File: rtl/srl_chk.sv
// Module: property checker for the latch controller, attached by bind.
module srl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       cmp1_stat,
    input logic       cmp2_stat,
    input logic       pin1_out,
    input logic       pin2_out,
    input logic       set_eff,
    input logic       rst_eff,
    input logic       latch_q
);
    // R1
    pin2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin2_out == (rd_data[7] ? latch_q : cmp2_stat));
    // R2
    pin1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin1_out == (rd_data[6] ? latch_q : cmp1_stat));
    // R3
    cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp1_stat && rd_data[5] && !rst_eff) |=> latch_q);
    // R4
    cmp_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp2_stat && rd_data[4]) |=> !latch_q);
    // R7
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3:0] == 4'h0);
    // R10
    rst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_eff |=> !latch_q);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_eff && !rst_eff) |=> $stable(latch_q));
    // R12
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[7:4] == $past(wr_data[7:4]));
endmodule

bind cmp_srlatch_ctrl srl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cmp1_stat (cmp1_stat),
    .cmp2_stat (cmp2_stat),
    .pin1_out  (pin1_out),
    .pin2_out  (pin2_out),
    .set_eff   (set_eff),
    .rst_eff   (rst_eff),
    .latch_q   (latch_q)
);

// File: tb/cmp_srlatch_ctrl_tb_top.sv
// Bench: sweeps every select/enable setting against all comparator levels
// and both prior latch states, then covers pulses, priority and latency.
module cmp_srlatch_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cmp1_in = 1'b0;
    logic       cmp2_in = 1'b0;
    logic       cmp1_stat, cmp2_stat, pin1_out, pin2_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    cmp_srlatch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cmp1_in(cmp1_in), .cmp2_in(cmp2_in),
        .cmp1_stat(cmp1_stat), .cmp2_stat(cmp2_stat),
        .pin1_out(pin1_out), .pin2_out(pin2_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    // Force a known latch state with comparators idle
    task automatic force_q(input logic v);
        cmp1_in = 1'b0; cmp2_in = 1'b0;
        wr(8'h00);
        tick(3);
        wr(v ? 8'h08 : 8'h04);
        tick(1);
    endtask

    // Read the latch through both pins in latch mode, enables off
    task automatic peek_q(input string req, input logic exp);
        wr(8'hC0);
        tick(1);
        check(req, {6'b0, pin2_out, pin1_out}, {6'b0, exp, exp});
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R8 reset state
        check("R8 rd", rd_data, 8'h00);
        check("R8 pins raw", {6'b0, pin2_out, pin1_out}, 8'h00);
        peek_q("R8 latch", 1'b0);

        // R1 R2 R3 R4 R9 R10 R12 sweep
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int c = 0; c < 4; c++) begin
                for (int q0 = 0; q0 < 2; q0++) begin
                    logic c1, c2, sel2, sel1, sen, ren, qe;
                    c1 = c[0]; c2 = c[1];
                    sel2 = cfg[3]; sel1 = cfg[2]; sen = cfg[1]; ren = cfg[0];
                    force_q(q0[0]);
                    cmp1_in = c1; cmp2_in = c2;
                    wr({cfg[3:0], 4'h0});
                    tick(4);
                    qe = (c2 && ren) ? 1'b0 : ((c1 && sen) ? 1'b1 : q0[0]);
                    check("R12 readback", rd_data, {cfg[3:0], 4'h0});
                    check("R9 status", {6'b0, cmp2_stat, cmp1_stat}, {6'b0, c2, c1});
                    check("R2 pin1", {7'b0, pin1_out}, {7'b0, sel1 ? qe : c1});
                    check("R1 pin2", {7'b0, pin2_out}, {7'b0, sel2 ? qe : c2});
                    peek_q("R3 R4 R10 latch", qe);
                end
            end
        end

        // R5 set pulse timing and readback
        force_q(1'b0);
        wr(8'hC0);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hC8;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
        check("R5 bit3 reads 0", rd_data, 8'hC0);
        check("R5 not yet set", {7'b0, pin1_out}, 8'h00);
        tick(1);
        check("R5 set", {7'b0, pin1_out}, 8'h01);
        // R6 reset pulse
        wr(8'hC4);
        check("R6 bit2 reads 0", rd_data, 8'hC0);
        tick(1);
        check("R6 cleared", {7'b0, pin1_out}, 8'h00);
        // R10 both pulses together
        force_q(1'b1);
        wr(8'hCC);
        tick(1);
        check("R10 both pulses", {6'b0, pin2_out, pin1_out}, 8'h00);
        // R10 pulse set against comparator reset
        force_q(1'b0);
        cmp2_in = 1'b1;
        wr(8'h10);
        tick(3);
        wr(8'hD8);
        tick(1);
        check("R10 pulse vs cmp reset", {6'b0, pin2_out, pin1_out}, 8'h00);
        // R7 low bits ignored
        force_q(1'b1);
        wr(8'h03);
        check("R7 rd", rd_data, 8'h00);
        peek_q("R7 latch kept", 1'b1);
        force_q(1'b0);
        wr(8'h03);
        peek_q("R7 latch kept 0", 1'b0);

        // R11 raw path latency
        force_q(1'b0);
        @(negedge clk); cmp1_in = 1'b1;
        @(posedge clk); #1;
        check("R11 raw 1 edge", {7'b0, pin1_out}, 8'h00);
        @(posedge clk); #1;
        check("R11 raw 2 edges", {7'b0, pin1_out}, 8'h01);
        check("R11 stat 2 edges", {7'b0, cmp1_stat}, 8'h01);
        // R11 latch path latency
        cmp1_in = 1'b0;
        force_q(1'b0);
        wr(8'h60);
        @(negedge clk); cmp1_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R11 latch 2 edges", {7'b0, pin1_out}, 8'h00);
        @(posedge clk); #1;
        check("R11 latch 3 edges", {7'b0, pin1_out}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule